// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital side of a two-channel 8-bit converter with a serial input. A host sends 16-bit command words on three wires: an active-low frame select, a serial clock and a data line. The block brings those wires into the system clock domain and assembles each word. Two address bits in the word then choose where its 8-bit code goes: the channel B latch, a shared holding register, the channel A latch, or a small control register. The control register picks the voltage reference.

Both channels can change in the same cycle. A code for channel B is first parked in the holding register. A later write to channel A then moves the parked code into channel B in the same update. Every accepted word also sets the speed-mode and power-down outputs. Power-down never touches the stored codes, so the converter outputs return to their earlier values when it ends. A one-cycle strobe tells the analog side that a channel code has changed.

Top module: `dual_dac_frontend`

## Requirements
- R1: A synchronous active-low reset clears both channel codes, the holding register and the reference field to zero, selects slow mode and leaves power-down deasserted (so `ext_ref_en` reads 1 and `upd_strobe` reads 0).
- R2: Data is sampled on each falling edge of `sclk` while `fs_n` is low, most significant bit first. A word is acted on at the rising edge of `fs_n`, and only if exactly 16 bits arrived. A frame with 15 or 17 bits leaves every output unchanged.
- R3: Word bit 15 is address high and bit 12 is address low. Bits 11 to 4 hold the code. Address 00 loads the code into channel B and also into the holding register.
- R4: Address 01 loads the code into the holding register only. Neither channel output changes.
- R5: Address 10 loads the code into channel A. In the same cycle, channel B takes the value the holding register had before that word.
- R6: Address 11 loads word bits 1:0 into `ref_sel` and leaves both channel codes unchanged. No other address changes `ref_sel`.
- R7: `ext_ref_en` is 1 when `ref_sel` is 00 or 11 and 0 when it is 01 or 10.
- R8: Word bit 14 (1 = fast) drives `fast_mode` and bit 13 (1 = power-down) drives `pwr_down`. Both are taken from every accepted word, whatever its address.
- R9: Entering and leaving power-down leaves both channel codes at the values they had before.
- R10: With two synchroniser stages, outputs change on the third system clock edge after `fs_n` rises. `upd_strobe` is high for exactly the following cycle, and only if a channel code took a different value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Serial clock, asynchronous |
| fs_n | input | 1 | Frame select, active low, asynchronous |
| sdi | input | 1 | Serial data, asynchronous |
| dac_a_code | output | 8 | Channel A code |
| dac_b_code | output | 8 | Channel B code |
| fast_mode | output | 1 | 1 selects fast settling |
| pwr_down | output | 1 | 1 requests power-down |
| ref_sel | output | 2 | Reference selection field |
| ext_ref_en | output | 1 | Enables the buffer for an external reference |
| upd_strobe | output | 1 | One-cycle pulse when a channel code changes |

## Verification
The key case is a word with address 10. It writes channel A and, in the same clock edge, moves the holding register into channel B. The bench first parks a code with address 01, then writes A. It expects both channel outputs to change on the same compare cycle, with B equal to the parked code and not to B's older value. The bench also sends a B write whose code equals the current one. That write must update the holding register but raise no strobe. This separates "a latch was written" from "a latch changed".

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   typedef enum logic [1:0] {
      DST_B_AND_HOLD = 2'b00,
      DST_HOLD_ONLY  = 2'b01,
      DST_A_PAIRED   = 2'b10,
      DST_CONTROL    = 2'b11
   } dst_e;

   typedef struct packed {
      logic       fast;
      logic       pdn;
      logic [1:0] refsel;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{fast: 1'b0, pdn: 1'b0, refsel: 2'b00};

   function automatic logic ref_is_external(input logic [1:0] r);
      return (r == 2'b00) || (r == 2'b11);
   endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dacfe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
   parameter int WORD_W    = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              fs_n_s,
   input  logic              sdi_s,
   output logic              frm_ok,
   output logic [WORD_W-1:0] frm_word
);

   localparam int CNT_W   = $clog2(WORD_W + 2);
   localparam int CNT_MAX = WORD_W + 1;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("dacfe_shifter: WORD_W too small");
      end
   endgenerate

   logic              sclk_q, fs_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sh_q, sh_next;
   logic              sclk_fall, fs_fall, fs_rise;

   assign sclk_fall = sclk_q & ~sclk_s;
   assign fs_fall   = fs_q & ~fs_n_s;
   assign fs_rise   = ~fs_q & fs_n_s;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next = {sh_q[WORD_W-2:0], sdi_s};
      end else begin : g_lsb
         assign sh_next = {sdi_s, sh_q[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
         fs_q   <= 1'b1;
         cnt_q  <= '0;
         sh_q   <= '0;
      end else begin
         sclk_q <= sclk_s;
         fs_q   <= fs_n_s;
         if (fs_fall) begin
            cnt_q <= '0;
         end else if (sclk_fall && !fs_n_s) begin
            sh_q <= sh_next;
            if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign frm_ok   = fs_rise && (cnt_q == CNT_W'(WORD_W));
   assign frm_word = sh_q;

endmodule

// File: rtl/dacfe_latches.sv
module dacfe_latches
   import dacfe_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_ok,
   input  logic [WORD_W-1:0] frm_word,
   output logic [DATA_W-1:0] dac_a,
   output logic [DATA_W-1:0] dac_b,
   output logic [DATA_W-1:0] hold,
   output ctrl_t             ctrl,
   output logic              strobe
);

   localparam int BIT_AH   = WORD_W - 1;
   localparam int BIT_SPD  = WORD_W - 2;
   localparam int BIT_PDN  = WORD_W - 3;
   localparam int BIT_AL   = WORD_W - 4;
   localparam int DATA_MSB = WORD_W - 5;

   generate
      if (WORD_W < DATA_W + 6) begin : g_bad_fit
         $error("dacfe_latches: word cannot hold control, code and ref bits");
      end
   endgenerate

   dst_e              dst;
   logic [DATA_W-1:0] code;
   logic [DATA_W-1:0] a_n, b_n, h_n;
   ctrl_t             c_n;

   assign dst  = dst_e'({frm_word[BIT_AH], frm_word[BIT_AL]});
   assign code = frm_word[DATA_MSB -: DATA_W];

   always_comb begin
      a_n = dac_a;
      b_n = dac_b;
      h_n = hold;
      c_n = ctrl;
      if (frm_ok) begin
         c_n.fast = frm_word[BIT_SPD];
         c_n.pdn  = frm_word[BIT_PDN];
         unique case (dst)
            DST_B_AND_HOLD: begin b_n = code; h_n = code; end
            DST_HOLD_ONLY:  h_n = code;
            DST_A_PAIRED:   begin a_n = code; b_n = hold; end
            DST_CONTROL:    c_n.refsel = frm_word[1:0];
            default:        ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_a  <= '0;
         dac_b  <= '0;
         hold   <= '0;
         ctrl   <= CTRL_RESET;
         strobe <= 1'b0;
      end else begin
         dac_a  <= a_n;
         dac_b  <= b_n;
         hold   <= h_n;
         ctrl   <= c_n;
         strobe <= (a_n != dac_a) || (b_n != dac_b);
      end
   end

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
   import dacfe_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              fs_n,
   input  logic              sdi,
   output logic [DATA_W-1:0] dac_a_code,
   output logic [DATA_W-1:0] dac_b_code,
   output logic              fast_mode,
   output logic              pwr_down,
   output logic [1:0]        ref_sel,
   output logic              ext_ref_en,
   output logic              upd_strobe
);

   logic [2:0]        pins_s;
   logic              frm_ok;
   logic [WORD_W-1:0] frm_word;
   logic [DATA_W-1:0] hold_q;
   ctrl_t             ctrl_q;

   dacfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, fs_n, sdi}),
      .q     (pins_s)
   );

   dacfe_shifter #(.WORD_W(WORD_W), .MSB_FIRST(1'b1)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (pins_s[2]),
      .fs_n_s   (pins_s[1]),
      .sdi_s    (pins_s[0]),
      .frm_ok   (frm_ok),
      .frm_word (frm_word)
   );

   dacfe_latches #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .frm_ok   (frm_ok),
      .frm_word (frm_word),
      .dac_a    (dac_a_code),
      .dac_b    (dac_b_code),
      .hold     (hold_q),
      .ctrl     (ctrl_q),
      .strobe   (upd_strobe)
   );

   assign fast_mode  = ctrl_q.fast;
   assign pwr_down   = ctrl_q.pdn;
   assign ref_sel    = ctrl_q.refsel;
   assign ext_ref_en = ref_is_external(ctrl_q.refsel);

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_ok,
   input logic [1:0]        frm_dst,
   input logic [DATA_W-1:0] dac_a,
   input logic [DATA_W-1:0] dac_b,
   input logic [DATA_W-1:0] hold,
   input logic [1:0]        ref_sel,
   input logic              strobe
);

   AST_A_HOLDS_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_ok |=> $stable(dac_a)); // R2

   AST_B_COPIED_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_ok && frm_dst == 2'b00) |=> (hold == dac_b)); // R3

   AST_HOLD_WRITE_KEEPS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_ok && frm_dst == 2'b01) |=> ($stable(dac_a) && $stable(dac_b))); // R4

   AST_B_TAKES_OLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_ok && frm_dst == 2'b10) |=> (dac_b == $past(hold))); // R5

   AST_REF_ONLY_ON_CONTROL: assert property (@(posedge clk) disable iff (!rst_n)
      !(frm_ok && frm_dst == 2'b11) |=> $stable(ref_sel)); // R6

   AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe); // R10

   AST_STROBE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (dac_a != $past(dac_a) || dac_b != $past(dac_b))); // R10

endmodule

bind dual_dac_frontend dacfe_checker #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .frm_ok  (frm_ok),
   .frm_dst ({frm_word[WORD_W-1], frm_word[WORD_W-4]}),
   .dac_a   (dac_a_code),
   .dac_b   (dac_b_code),
   .hold    (hold_q),
   .ref_sel (ref_sel),
   .strobe  (upd_strobe)
);

// File: tb/test_dual_dac_frontend.sv
`timescale 1ns/1ps
module test_dual_dac_frontend;

   localparam int LAT = 3;  // two sync stages plus edge detect (R10)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b1, fs_n = 1'b1, sdi = 1'b0;
   logic [7:0] dac_a_code, dac_b_code;
   logic       fast_mode, pwr_down, ext_ref_en, upd_strobe;
   logic [1:0] ref_sel;

   always #2 clk = ~clk;

   dual_dac_frontend i_dual_dac_frontend (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs_n(fs_n), .sdi(sdi),
      .dac_a_code(dac_a_code), .dac_b_code(dac_b_code),
      .fast_mode(fast_mode), .pwr_down(pwr_down), .ref_sel(ref_sel),
      .ext_ref_en(ext_ref_en), .upd_strobe(upd_strobe)
   );

   // behavioural reference
   int          vectors = 0, miscompares = 0;
   bit          compare_on = 0;
   string       req = "R1";
   int          m_a = 0, m_b = 0, m_h = 0, m_ref = 0;
   bit          m_fast = 0, m_pdn = 0, m_stb = 0;
   int          pend = 0;
   logic [15:0] pend_word;

   task automatic model_apply(input logic [15:0] w);
      int old_a = m_a, old_b = m_b, code = int'(w[11:4]);
      m_fast = w[14];
      m_pdn  = w[13];
      case ({w[15], w[12]})
         2'b00: begin m_b = code; m_h = code; end
         2'b01: m_h = code;
         2'b10: begin m_a = code; m_b = m_h; end
         default: m_ref = int'(w[1:0]);
      endcase
      m_stb = (m_a != old_a) || (m_b != old_b);
   endtask

   always @(posedge clk) begin
      m_stb = 0;
      if (!rst_n) begin
         m_a = 0; m_b = 0; m_h = 0; m_ref = 0; m_fast = 0; m_pdn = 0; pend = 0;
      end else if (pend > 0) begin
         pend--;
         if (pend == 0) model_apply(pend_word);
      end
   end

   task automatic cmp(input string name, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, name, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (compare_on) begin
         cmp("dac_a", int'(dac_a_code), m_a);
         cmp("dac_b", int'(dac_b_code), m_b);
         cmp("fast_mode", int'(fast_mode), int'(m_fast));
         cmp("pwr_down", int'(pwr_down), int'(m_pdn));
         cmp("ref_sel", int'(ref_sel), m_ref);
         cmp("ext_ref_en", int'(ext_ref_en), int'(m_ref == 0 || m_ref == 3)); // R7
         cmp("upd_strobe", int'(upd_strobe), int'(m_stb));
      end
   end

   // nbits != 16 gives a discarded frame (R2)
   task automatic send(input logic [15:0] w, input int nbits);
      @(negedge clk);
      fs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdi  = w[15 - (i % 16)];
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
         repeat (4) @(negedge clk);
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      fs_n = 1'b1;
      if (nbits == 16) begin
         pend_word = w;
         pend = LAT;
      end
      repeat (8) @(negedge clk);
   endtask

   function automatic logic [15:0] mk(input bit ah, input bit al, input bit spd,
                                      input bit pdn, input logic [7:0] code,
                                      input logic [1:0] rf);
      return {ah, spd, pdn, al, code, 2'b00, rf};
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      compare_on = 1;               // R1: reset values compared while held
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      req = "R3"; send(mk(0, 0, 0, 0, 8'h5A, 2'b00), 16);
      req = "R5"; send(mk(1, 0, 0, 0, 8'hC3, 2'b00), 16);  // B reloads same 5A
      req = "R4"; send(mk(0, 1, 0, 0, 8'h77, 2'b00), 16);
      req = "R5"; send(mk(1, 0, 0, 0, 8'h11, 2'b00), 16);  // A=11, B=77 together
      req = "R10"; send(mk(0, 0, 0, 0, 8'h77, 2'b00), 16); // same value, no strobe
      req = "R6"; send(mk(1, 1, 0, 0, 8'hFF, 2'b01), 16);
      req = "R7"; send(mk(1, 1, 0, 0, 8'h00, 2'b10), 16);
      req = "R7"; send(mk(1, 1, 0, 0, 8'h00, 2'b11), 16);
      req = "R8"; send(mk(0, 1, 1, 0, 8'h3C, 2'b00), 16);  // fast from a hold write
      req = "R9"; send(mk(1, 1, 1, 1, 8'h00, 2'b11), 16);  // enter power-down
      req = "R9"; send(mk(1, 1, 0, 0, 8'h00, 2'b11), 16);  // leave, codes kept
      req = "R2"; send(mk(0, 0, 1, 1, 8'hE1, 2'b00), 15);
      req = "R2"; send(mk(1, 0, 1, 1, 8'hE2, 2'b00), 17);
      req = "R2"; send(16'h8A50, 16);                      // MSB-first: A=A5
      req = "R8"; send(mk(1, 0, 1, 0, 8'h96, 2'b00), 16);  // A=96, B=3C
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule